// File: doc/BRIEF.md
# Power-Management Control Register with Sleep Decode

This block holds a 16-bit power-management control word on a little-endian bus that can be accessed a byte or a halfword at a time. The word carries an interrupt-mode enable bit and a 3-bit sleep-type field. It also has a request bit that software sets to ask for a sleep transition. That request bit is never stored. When a write carries it, the block decodes the written sleep type into one of three single-cycle action pulses: soft power-off, suspend-to-RAM or hibernate. The system logic that carries out the transition watches these pulses.

The sleep-type value that means hibernate is supplied on an input, so the integrating chip chooses it. A hardware-only mode input pins the interrupt-mode enable bit high. In that mode the external enable and disable requests have no effect. Outside that mode, those requests set and clear the bit directly.

Top module: `pm_ctrl_reg`

## Requirements
- R1: When reset is released with hwOnlyMode low, the register reads 0x0000 at offset 0.
- R2: When reset is released with hwOnlyMode high, the register reads 0x0001 at offset 0, so only the interrupt-mode bit (bit 0) is set.
- R3: A halfword write at offset 0 stores wrData with bit 13 (the sleep request) forced to 0, so bit 13 always reads back as 0.
- R4: A byte write at offset 0 stores wrData[7:0] as the low byte and zeroes the high byte.
- R5: A byte write at offset 1 stores wrData[7:0] as the high byte and keeps the stored low byte. The sleep decode uses this merged value.
- R6: Reads are combinational. rdOffset 1 returns the stored word shifted right by 8, with the upper 8 bits zero.
- R7: In the cycle after a write whose merged value has bit 13 set and a sleep type (bits 12:10) of 0, powerOffPulse is high.
- R8: In the same situation with a sleep type of 1, suspendPulse is high.
- R9: With bit 13 set and a sleep type of 2 or more that equals hibernateCode, hibernatePulse is high. Any other type of 2 or more gives no pulse, and a write without bit 13 gives no pulse.
- R10: Each pulse lasts one cycle unless the next write repeats the request, and at most one pulse is high in any cycle.
- R11: With hwOnlyMode low, sciEnReq sets bit 0 at the next edge. sciDisReq alone clears it. If both are high, bit 0 is set. A request overrides bit 0 of a write in the same cycle.
- R12: With hwOnlyMode high, bit 0 stays 1 whatever the requests do and whatever value is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwOnlyMode | input | 1 | Locks the interrupt-mode bit high |
| hibernateCode | input | 3 | Sleep-type value that requests hibernate |
| wrEn | input | 1 | Write strobe |
| wrOffset | input | 1 | Byte offset of the write |
| wrHalf | input | 1 | 1 = halfword write, 0 = byte write |
| wrData | input | 16 | Write data; a byte write uses bits 7:0 |
| rdOffset | input | 1 | Byte offset of the read |
| rdData | output | 16 | Read data |
| sciEnReq | input | 1 | External request to set the interrupt-mode bit |
| sciDisReq | input | 1 | External request to clear the interrupt-mode bit |
| powerOffPulse | output | 1 | Soft power-off request pulse |
| suspendPulse | output | 1 | Suspend-to-RAM request pulse |
| hibernatePulse | output | 1 | Hibernate request pulse |

## Verification
The case that is hardest to reach is a high-byte write whose sleep request has to be decoded together with a sleep type spread across the merged word. It is hardest when an interrupt-mode request arrives in the same cycle. Random traffic rarely hits the hibernate code at the same moment. The bench therefore biases the sleep-request bit to half of all writes and draws the sleep type across its full range against a fixed hibernate code. It also adds directed byte writes at offset 1 and directed simultaneous write-plus-request cycles. Both reset modes are covered by resetting a second time with the hardware-only mode input raised.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;
  typedef struct packed {
    logic wrStore;
    logic setSci;
    logic clrSci;
    logic forceSci;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_OFF     = 2'd1,
    ACT_SUSPEND = 2'd2,
    ACT_HIBER   = 2'd3
  } sleepAct_e;
endpackage

// File: rtl/pm_ctrl_dp.sv
module pm_ctrl_dp
  import pm_ctrl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SLP_EN_BIT = 13,
  parameter int SCI_BIT    = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hwOnlyMode,
  input  ctrlStrobes_t        strobes,
  input  logic [$clog2(DATA_W/8)-1:0] wrOffset,
  input  logic                wrHalf,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [$clog2(DATA_W/8)-1:0] rdOffset,
  output logic [DATA_W-1:0]   mergedVal,
  output logic [DATA_W-1:0]   ctrlQ,
  output logic [DATA_W-1:0]   rdData
);
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = DATA_W / BYTE_W;
  localparam int OFS_W     = $clog2(NUM_BYTES);
  localparam logic [DATA_W-1:0] SLP_MASK = DATA_W'(1) << SLP_EN_BIT;

  logic fullWrite;
  assign fullWrite = wrHalf && (wrOffset == '0);

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    always_comb begin
      if (fullWrite)
        mergedVal[i*BYTE_W +: BYTE_W] = wrData[i*BYTE_W +: BYTE_W];
      else if (OFS_W'(i) == wrOffset)
        mergedVal[i*BYTE_W +: BYTE_W] = wrData[BYTE_W-1:0];
      else if (OFS_W'(i) < wrOffset)
        mergedVal[i*BYTE_W +: BYTE_W] = ctrlQ[i*BYTE_W +: BYTE_W];
      else
        mergedVal[i*BYTE_W +: BYTE_W] = '0;
    end
  end

  logic [DATA_W-1:0] ctrlD;
  always_comb begin
    ctrlD = ctrlQ;
    if (strobes.wrStore) ctrlD = mergedVal & ~SLP_MASK;
    if (strobes.forceSci)    ctrlD[SCI_BIT] = 1'b1;
    else if (strobes.setSci) ctrlD[SCI_BIT] = 1'b1;
    else if (strobes.clrSci) ctrlD[SCI_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ          <= '0;
      ctrlQ[SCI_BIT] <= hwOnlyMode;
    end else begin
      ctrlQ <= ctrlD;
    end
  end

  assign rdData = ctrlQ >> (BYTE_W * int'(rdOffset));
endmodule

// File: rtl/pm_ctrl_ctl.sv
module pm_ctrl_ctl
  import pm_ctrl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SLP_EN_BIT = 13,
  parameter int TYP_LSB    = 10,
  parameter int TYP_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hwOnlyMode,
  input  logic [TYP_W-1:0]   hibernateCode,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  mergedVal,
  input  logic               sciEnReq,
  input  logic               sciDisReq,
  output ctrlStrobes_t       strobes,
  output logic               powerOffPulse,
  output logic               suspendPulse,
  output logic               hibernatePulse
);
  localparam logic [TYP_W-1:0] TYP_OFF = TYP_W'(0);
  localparam logic [TYP_W-1:0] TYP_SUS = TYP_W'(1);

  logic [TYP_W-1:0] sleepTyp;
  sleepAct_e        actD;

  assign sleepTyp = mergedVal[TYP_LSB +: TYP_W];

  always_comb begin
    strobes.wrStore  = wrEn;
    strobes.forceSci = hwOnlyMode;
    strobes.setSci   = !hwOnlyMode && sciEnReq;
    strobes.clrSci   = !hwOnlyMode && sciDisReq && !sciEnReq;
  end

  always_comb begin
    actD = ACT_NONE;
    if (wrEn && mergedVal[SLP_EN_BIT]) begin
      if (sleepTyp == TYP_OFF)            actD = ACT_OFF;
      else if (sleepTyp == TYP_SUS)       actD = ACT_SUSPEND;
      else if (sleepTyp == hibernateCode) actD = ACT_HIBER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerOffPulse  <= 1'b0;
      suspendPulse   <= 1'b0;
      hibernatePulse <= 1'b0;
    end else begin
      powerOffPulse  <= (actD == ACT_OFF);
      suspendPulse   <= (actD == ACT_SUSPEND);
      hibernatePulse <= (actD == ACT_HIBER);
    end
  end
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pm_ctrl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SLP_EN_BIT = 13,
  parameter int TYP_LSB    = 10,
  parameter int TYP_W      = 3,
  parameter int SCI_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwOnlyMode,
  input  logic [TYP_W-1:0]  hibernateCode,
  input  logic              wrEn,
  input  logic              wrOffset,
  input  logic              wrHalf,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdOffset,
  output logic [DATA_W-1:0] rdData,
  input  logic              sciEnReq,
  input  logic              sciDisReq,
  output logic              powerOffPulse,
  output logic              suspendPulse,
  output logic              hibernatePulse
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] mergedVal;
  logic [DATA_W-1:0] ctrlQ;

  pm_ctrl_ctl #(
    .DATA_W(DATA_W), .SLP_EN_BIT(SLP_EN_BIT), .TYP_LSB(TYP_LSB), .TYP_W(TYP_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .hwOnlyMode(hwOnlyMode),
    .hibernateCode(hibernateCode), .wrEn(wrEn), .mergedVal(mergedVal),
    .sciEnReq(sciEnReq), .sciDisReq(sciDisReq), .strobes(strobes),
    .powerOffPulse(powerOffPulse), .suspendPulse(suspendPulse),
    .hibernatePulse(hibernatePulse)
  );

  pm_ctrl_dp #(
    .DATA_W(DATA_W), .SLP_EN_BIT(SLP_EN_BIT), .SCI_BIT(SCI_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hwOnlyMode(hwOnlyMode), .strobes(strobes),
    .wrOffset(wrOffset), .wrHalf(wrHalf), .wrData(wrData),
    .rdOffset(rdOffset), .mergedVal(mergedVal), .ctrlQ(ctrlQ), .rdData(rdData)
  );
endmodule

// File: rtl/pm_ctrl_chk.sv
module pm_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hwOnlyMode,
  input logic        wrEn,
  input logic        wrOffset,
  input logic        wrHalf,
  input logic [15:0] wrData,
  input logic        sciEnReq,
  input logic        sciDisReq,
  input logic [15:0] ctrlQ,
  input logic        powerOffPulse,
  input logic        suspendPulse,
  input logic        hibernatePulse
);
  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({powerOffPulse, suspendPulse, hibernatePulse}));

  // R3
  no_sleep_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[13]);

  // R7
  off_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrOffset && wrHalf && wrData[13] && wrData[12:10] == 3'd0)
    |=> powerOffPulse);

  // R8
  sus_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrOffset && wrHalf && wrData[13] && wrData[12:10] == 3'd1)
    |=> suspendPulse);

  // R11
  sci_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hwOnlyMode && sciEnReq) |=> ctrlQ[0]);

  // R11
  sci_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hwOnlyMode && sciDisReq && !sciEnReq) |=> !ctrlQ[0]);

  // R12
  sci_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwOnlyMode |=> ctrlQ[0]);

  // R9
  no_req_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !(powerOffPulse || suspendPulse || hibernatePulse));
endmodule

bind pm_ctrl_reg pm_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .hwOnlyMode(hwOnlyMode), .wrEn(wrEn),
  .wrOffset(wrOffset), .wrHalf(wrHalf), .wrData(wrData),
  .sciEnReq(sciEnReq), .sciDisReq(sciDisReq), .ctrlQ(ctrlQ),
  .powerOffPulse(powerOffPulse), .suspendPulse(suspendPulse),
  .hibernatePulse(hibernatePulse)
);

// File: tb/sim_pm_ctrl_reg.sv
`timescale 1ns/1ps
module sim_pm_ctrl_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hwOnlyMode = 1'b0;
  logic [2:0]  hibernateCode = 3'd5;
  logic        wrEn = 1'b0, wrOffset = 1'b0, wrHalf = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdOffset = 1'b0;
  logic [15:0] rdData;
  logic        sciEnReq = 1'b0, sciDisReq = 1'b0;
  logic        powerOffPulse, suspendPulse, hibernatePulse;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [15:0] model = '0;

  always #4 clk = ~clk;

  pm_ctrl_reg u0 (.*);

  function automatic logic [15:0] mergeFn(logic [15:0] cur, logic ofs,
                                          logic half, logic [15:0] d);
    if (half && !ofs) return d;
    if (ofs) return {d[7:0], cur[7:0]};
    return {8'h00, d[7:0]};
  endfunction

  function automatic logic [2:0] actFn(logic [15:0] m, logic [2:0] hib);
    if (!m[13]) return 3'b000;
    if (m[12:10] == 3'd0) return 3'b001;
    if (m[12:10] == 3'd1) return 3'b010;
    if (m[12:10] == hib)  return 3'b100;
    return 3'b000;
  endfunction

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readBoth(string tag);
    rdOffset = 1'b0; #1;
    cmp({tag, " rd0"}, rdData, model);
    rdOffset = 1'b1; #1;
    // R6
    cmp({tag, " R6 rd1"}, rdData, {8'h00, model[15:8]});
    rdOffset = 1'b0;
  endtask

  task automatic step(string tag, logic we, logic ofs, logic half,
                      logic [15:0] d, logic en, logic dis);
    logic [2:0] expAct;
    logic [15:0] m;
    wrEn = we; wrOffset = ofs; wrHalf = half; wrData = d;
    sciEnReq = en; sciDisReq = dis;
    expAct = 3'b000;
    if (we) begin
      m = mergeFn(model, ofs, half, d);
      expAct = actFn(m, hibernateCode);
      model = m & ~16'h2000;
    end
    if (hwOnlyMode) model[0] = 1'b1;
    else if (en)    model[0] = 1'b1;
    else if (dis)   model[0] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; sciEnReq = 1'b0; sciDisReq = 1'b0;
    // R7 R8 R9 R10
    cmp({tag, " R7/R8/R9/R10 pulses"},
        {13'd0, hibernatePulse, suspendPulse, powerOffPulse}, {13'd0, expAct});
    readBoth(tag);
  endtask

  task automatic doReset(logic hw);
    hwOnlyMode = hw;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    model = hw ? 16'h0001 : 16'h0000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    doReset(1'b0);
    @(negedge clk);
    // R1
    readBoth("R1 reset normal");
    // R3
    step("R3 half write", 1, 0, 1, 16'hF0A5 & ~16'h2000, 0, 0);
    step("R3 sleep bit dropped", 1, 0, 1, 16'h2000 | 16'h1C00 | 16'h00F0, 0, 0);
    // R4
    step("R4 byte low", 1, 0, 0, 16'hBE42, 0, 0);
    // R5
    step("R5 byte high keep low", 1, 1, 0, 16'h00C3, 0, 0);
    // R5 R8: high byte 0x24 -> bit13 set, type 1
    step("R5 R8 high byte suspend", 1, 1, 0, 16'h0024, 0, 0);
    // R7
    step("R7 off", 1, 0, 1, 16'h2000, 0, 0);
    // R9 hibernate code 5
    step("R9 hiber", 1, 0, 1, 16'h2000 | (16'd5 << 10), 0, 0);
    step("R9 other type", 1, 0, 1, 16'h2000 | (16'd6 << 10), 0, 0);
    step("R9 no request", 1, 0, 1, 16'd1 << 10, 0, 0);
    // R10
    step("R10 pulse drops", 0, 0, 0, 16'h0, 0, 0);
    // R11
    step("R11 set", 0, 0, 0, 16'h0, 1, 0);
    step("R11 clear", 0, 0, 0, 16'h0, 0, 1);
    step("R11 both", 0, 0, 0, 16'h0, 1, 1);
    step("R11 req over write", 1, 0, 1, 16'h0000, 1, 0);
    step("R11 dis over write", 1, 0, 1, 16'h0001, 0, 1);
    for (int k = 0; k < 400; k++) begin
      logic [15:0] d;
      d = 16'($urandom);
      d[13] = $urandom_range(0, 1) != 0;
      step("rand normal", $urandom_range(0, 3) != 0, 1'($urandom), 1'($urandom),
           d, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
    end
    hibernateCode = 3'd3;
    doReset(1'b1);
    @(negedge clk);
    // R2
    readBoth("R2 reset hw-only");
    // R12
    step("R12 dis ignored", 0, 0, 0, 16'h0, 0, 1);
    step("R12 write zero", 1, 0, 1, 16'h0000, 0, 1);
    step("R9 hiber code 3", 1, 0, 1, 16'h2000 | (16'd3 << 10), 0, 0);
    for (int k = 0; k < 200; k++) begin
      logic [15:0] d;
      d = 16'($urandom);
      d[13] = $urandom_range(0, 1) != 0;
      step("R12 rand hw-only", $urandom_range(0, 2) != 0, 1'($urandom), 1'($urandom),
           d, 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule